// File: doc/BRIEF.md
# H-Bridge Gate Control and Fault Logic

This block is the digital core of a full H-bridge motor driver. Each leg has a direction input. One shared PWM line modulates the low-side switches only. Each leg also has a sensed enable line, which the block can pull low itself. From these the block produces four registered gate commands: a high-side and a low-side command for each leg. Comparator flags from the analog section are inputs: supply undervoltage and overvoltage, a per-leg high-side temperature trip with a separate cool-down flag, per-leg low-side saturation, a test-mode request, and per-leg load-continuity loss.

Every external input first passes through a multi-flop synchronizer. When a leg reports a fault, that leg is latched off and its diagnostic pulldown is asserted. The latch is released only by a fresh low-to-high edge on that leg's direction input. A supply excursion turns every switch off, and the bridge recovers by itself once the supply is back in range. A programmable dead time keeps the two switches of one leg from overlapping.

Top module: `hbridge_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, all of `hs`, `ls` and `diag_pd` are 0.
- R2: Conditions: supply good, no fault, enable high, PWM high, test off. Bit 0 of each vector is leg A and bit 1 is leg B. A leg's high-side command is 1 when its direction input is 1, and its low-side command is 1 when the input is 0. A change on a direction input reaches the gate outputs on the third rising clock edge after it is applied.
- R3: When PWM is low, both low-side commands are 0. The high-side commands still follow the direction inputs. When PWM returns high, the low-side commands are restored for legs whose input is 0.
- R4: A leg whose sensed enable is 0 drives both of its gates to 0. The other leg is unaffected.
- R5: A high-side temperature trip or a low-side saturation flag on a leg sets that leg's fault latch. While the latch is set, both gates of that leg are 0 and its `diag_pd` bit is 1.
- R6: A set fault latch is cleared only by a 0-to-1 transition of that leg's direction input. A direction input that stays at 1 leaves the latch set.
- R7: While one leg is faulted, the other leg keeps following its own direction input.
- R8: When the undervoltage or overvoltage flag is high, all four gates are 0. Normal operation resumes without any other action once both flags are low.
- R9: Once tripped, the temperature condition persists until the cool-down flag is 1. Before that, a rising edge on the direction input does not release the leg.
- R10: In test mode, both low-side commands are 0 and each high-side command equals its direction input. A leg whose load-continuity-loss flag is 1 has its `diag_pd` bit at 1.
- R11: The two gates of one leg are never 1 together. After one of them falls, the other rises no earlier than DT_CYCLES+1 clock cycles later, and exactly then if it was already being requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_in | input | 2 | Direction input per leg (bit 0 = A, bit 1 = B) |
| pwm | input | 1 | Low-side modulation input |
| en_in | input | 2 | Sensed level of each leg's enable/diagnostic line |
| uv_flag | input | 1 | Supply below valid range |
| ov_flag | input | 1 | Supply above valid range |
| ot_trip | input | 2 | High-side temperature above trip threshold, per leg |
| ot_cool | input | 2 | High-side temperature below reset threshold, per leg |
| sat_flag | input | 2 | Low-side drain-source voltage above reference, per leg |
| test_req | input | 1 | Load-continuity test mode request |
| noload | input | 2 | No load continuity seen on leg output during test |
| hs | output | 2 | High-side gate command per leg |
| ls | output | 2 | Low-side gate command per leg |
| diag_pd | output | 2 | Diagnostic pulldown enable per leg |

## Verification
The bench builds the block with SYNC_STAGES = 2 and DT_CYCLES = 3. With two synchronizer stages, the three-edge input-to-gate latency can be sampled edge by edge. With a dead time of 3, the exact rise edge of the complementary switch during a direction reversal falls inside a short window, where both the early and the exact edge are checked. These small values also let the fault-release, temperature hysteresis and supply-recovery sequences finish in a few dozen cycles each.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int NLEG = 2;

  typedef struct packed {
    logic hs;
    logic ls;
  } gate_req_t;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hb_fault.sv
module hb_fault (
  input  logic clk,
  input  logic rst,
  input  logic dir_lvl,
  input  logic ot_trip,
  input  logic ot_cool,
  input  logic sat,
  output logic fault_nxt
);
  logic hot_q, fault_q, dir_d;
  logic hot_nxt, dir_rise;

  always_comb begin
    hot_nxt   = ot_trip | (hot_q & ~ot_cool);
    dir_rise  = dir_lvl & ~dir_d;
    fault_nxt = hot_nxt | sat | (fault_q & ~dir_rise);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hot_q   <= 1'b0;
      fault_q <= 1'b0;
      dir_d   <= 1'b0;
    end else begin
      hot_q   <= hot_nxt;
      fault_q <= fault_nxt;
      dir_d   <= dir_lvl;
    end
  end
endmodule

// File: rtl/hb_gate.sv
module hb_gate
  import hb_pkg::*;
#(
  parameter int DT_CYCLES = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  gate_req_t req,
  output logic      hs_q,
  output logic      ls_q
);
  localparam int CW = $clog2(DT_CYCLES + 2);
  localparam logic [CW-1:0] GAP_MAX = CW'(DT_CYCLES);

  logic [CW-1:0] hs_gap, ls_gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q   <= 1'b0;
      ls_q   <= 1'b0;
      hs_gap <= GAP_MAX;
      ls_gap <= GAP_MAX;
    end else begin
      hs_q   <= req.hs & ~ls_q & (ls_gap == GAP_MAX);
      ls_q   <= req.ls & ~hs_q & (hs_gap == GAP_MAX);
      hs_gap <= hs_q ? '0 : ((hs_gap == GAP_MAX) ? GAP_MAX : hs_gap + 1'b1);
      ls_gap <= ls_q ? '0 : ((ls_gap == GAP_MAX) ? GAP_MAX : ls_gap + 1'b1);
    end
  end
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
  import hb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DT_CYCLES   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NLEG-1:0] dir_in,
  input  logic            pwm,
  input  logic [NLEG-1:0] en_in,
  input  logic            uv_flag,
  input  logic            ov_flag,
  input  logic [NLEG-1:0] ot_trip,
  input  logic [NLEG-1:0] ot_cool,
  input  logic [NLEG-1:0] sat_flag,
  input  logic            test_req,
  input  logic [NLEG-1:0] noload,
  output logic [NLEG-1:0] hs,
  output logic [NLEG-1:0] ls,
  output logic [NLEG-1:0] diag_pd
);
  localparam int RAW_W = 6 * NLEG + 4;

  logic [RAW_W-1:0] raw, synced;
  logic [NLEG-1:0]  s_dir, s_en, s_trip, s_cool, s_sat, s_noload;
  logic             s_pwm, s_uv, s_ov, s_test;
  logic             supply_bad;

  assign raw = {test_req, ov_flag, uv_flag, pwm,
                noload, sat_flag, ot_cool, ot_trip, en_in, dir_in};

  hb_sync #(.W(RAW_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(synced)
  );

  assign {s_test, s_ov, s_uv, s_pwm,
          s_noload, s_sat, s_cool, s_trip, s_en, s_dir} = synced;

  assign supply_bad = s_uv | s_ov;

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    logic      fault_nxt, leg_off;
    gate_req_t req;

    hb_fault u_fault (
      .clk(clk), .rst(rst), .dir_lvl(s_dir[g]),
      .ot_trip(s_trip[g]), .ot_cool(s_cool[g]), .sat(s_sat[g]),
      .fault_nxt(fault_nxt)
    );

    always_comb begin
      leg_off = supply_bad | fault_nxt | ~s_en[g];
      req.hs  = ~leg_off & s_dir[g];
      req.ls  = ~leg_off & ~s_test & ~s_dir[g] & s_pwm;
    end

    hb_gate #(.DT_CYCLES(DT_CYCLES)) u_gate (
      .clk(clk), .rst(rst), .req(req), .hs_q(hs[g]), .ls_q(ls[g])
    );

    always_ff @(posedge clk) begin
      if (rst) diag_pd[g] <= 1'b0;
      else     diag_pd[g] <= fault_nxt | (s_test & s_noload[g]);
    end
  end
endmodule

// File: rtl/hbridge_ctrl_chk.sv
module hbridge_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] hs,
  input logic [1:0] ls,
  input logic [1:0] diag_pd,
  input logic       s_pwm,
  input logic       s_uv,
  input logic       s_ov,
  input logic       s_test
);
  // R11: no overlap within a leg
  a_r11_no_overlap_a: assert property (@(posedge clk) disable iff (rst)
    !(hs[0] && ls[0]));
  a_r11_no_overlap_b: assert property (@(posedge clk) disable iff (rst)
    !(hs[1] && ls[1]));
  // R11: a low side only rises after its high side was already off
  a_r11_ls_after_hs: assert property (@(posedge clk) disable iff (rst)
    $rose(ls[0]) |-> !$past(hs[0]));
  // R3: synchronized PWM low clears both low sides on the next edge
  a_r3_pwm_gates_ls: assert property (@(posedge clk) disable iff (rst)
    !s_pwm |=> (ls == 2'b00));
  // R8: supply out of range clears every gate on the next edge
  a_r8_supply_off: assert property (@(posedge clk) disable iff (rst)
    (s_uv || s_ov) |=> (hs == 2'b00 && ls == 2'b00));
  // R5: a fault-driven pulldown means the leg is off
  a_r5_fault_leg_off_a: assert property (@(posedge clk) disable iff (rst)
    (diag_pd[0] && !$past(s_test)) |-> (!hs[0] && !ls[0]));
  a_r5_fault_leg_off_b: assert property (@(posedge clk) disable iff (rst)
    (diag_pd[1] && !$past(s_test)) |-> (!hs[1] && !ls[1]));
endmodule

bind hbridge_ctrl hbridge_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .hs(hs), .ls(ls), .diag_pd(diag_pd),
  .s_pwm(s_pwm), .s_uv(s_uv), .s_ov(s_ov), .s_test(s_test)
);

// File: tb/hbridge_ctrl_tb.sv
module hbridge_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] dir_in = 2'b00, en_in = 2'b11, ot_trip = 2'b00, ot_cool = 2'b11;
  logic [1:0] sat_flag = 2'b00, noload = 2'b00;
  logic       pwm = 1'b1, uv_flag = 1'b0, ov_flag = 1'b0, test_req = 1'b0;
  logic [1:0] hs, ls, diag_pd;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  hbridge_ctrl #(.SYNC_STAGES(2), .DT_CYCLES(3)) u_dut (
    .clk(clk), .rst(rst), .dir_in(dir_in), .pwm(pwm), .en_in(en_in),
    .uv_flag(uv_flag), .ov_flag(ov_flag), .ot_trip(ot_trip), .ot_cool(ot_cool),
    .sat_flag(sat_flag), .test_req(test_req), .noload(noload),
    .hs(hs), .ls(ls), .diag_pd(diag_pd)
  );

  // {dirA, dirB, pwm, enA, enB, hsB, hsA, lsB, lsA}
  localparam logic [8:0] VEC [10] = '{
    9'b11111_11_00, 9'b10111_01_10, 9'b01111_10_01, 9'b00111_00_11,
    9'b00011_00_00, 9'b10011_01_00, 9'b01011_10_00,
    9'b00101_00_10, 9'b11110_01_00, 9'b10100_00_00
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    #(100000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(5);
    check("R1 in reset", {hs, ls, diag_pd}, 6'b0);
    rst = 1'b0;
    step(1);
    check("R1 after release", {hs, ls, diag_pd}, 6'b0);

    for (int i = 0; i < 10; i++) begin
      {dir_in[0], dir_in[1], pwm, en_in[0], en_in[1]} = VEC[i][8:4];
      step(10);
      check(i < 4 ? "R2 table" : (i < 7 ? "R3 table" : "R4 table"),
            {hs, ls, 2'b00}, {VEC[i][3:0], 2'b00});
    end

    // R2 latency: dirA=1 dirB=0 -> drop dirA, hs A falls on 3rd edge
    en_in = 2'b11; pwm = 1'b1; dir_in = 2'b01;
    step(10);
    dir_in = 2'b00;
    step(2);
    check("R2 latency edge2", {4'b0, hs[0], 1'b0}, 6'b000010);
    step(1);
    check("R2 latency edge3", {4'b0, hs[0], 1'b0}, 6'b000000);

    // R11 dead time on leg B: ls B on, then reverse
    step(10);
    dir_in = 2'b10;
    step(3);
    check("R11 ls off edge3", {4'b0, hs[1], ls[1]}, 6'b000000);
    step(3);
    check("R11 hs still off edge6", {5'b0, hs[1]}, 6'b0);
    step(1);
    check("R11 hs on edge7", {5'b0, hs[1]}, 6'b1);
    dir_in = 2'b00;
    step(6);
    check("R11 ls still off edge6", {5'b0, ls[1]}, 6'b0);
    step(1);
    check("R11 ls on edge7", {5'b0, ls[1]}, 6'b1);

    // R5/R6/R7 saturation fault on leg A
    dir_in = 2'b01;
    step(10);
    sat_flag = 2'b01;
    step(3);
    check("R5 sat fault", {hs, ls, diag_pd}, {2'b00, 2'b10, 2'b01});
    sat_flag = 2'b00;
    step(8);
    check("R6 steady high keeps latch", {hs, ls, diag_pd}, {2'b00, 2'b10, 2'b01});
    dir_in = 2'b11;
    step(10);
    check("R7 leg B follows", {hs, ls, diag_pd}, {2'b10, 2'b00, 2'b01});
    dir_in = 2'b10;
    step(5);
    dir_in = 2'b11;
    step(6);
    check("R6 rising edge releases", {hs, ls, diag_pd}, {2'b11, 2'b00, 2'b00});

    // R9 temperature hysteresis on leg B
    ot_trip = 2'b10; ot_cool = 2'b01;
    step(4);
    check("R5 overtemp fault", {hs, diag_pd}, {2'b01, 2'b10});
    ot_trip = 2'b00;
    step(3);
    dir_in = 2'b01;
    step(4);
    dir_in = 2'b11;
    step(8);
    check("R9 no release while warm", {hs, diag_pd}, {2'b01, 2'b10});
    ot_cool = 2'b11;
    step(8);
    check("R9 cool but no edge", {hs, diag_pd}, {2'b01, 2'b10});
    dir_in = 2'b01;
    step(4);
    dir_in = 2'b11;
    step(8);
    check("R9 release after cool", {hs, diag_pd}, {2'b11, 2'b00});

    // R8 supply excursions
    dir_in = 2'b01;
    step(10);
    uv_flag = 1'b1;
    step(3);
    check("R8 undervoltage", {hs, ls, diag_pd}, 6'b0);
    uv_flag = 1'b0;
    step(10);
    check("R8 recovery uv", {hs, ls, diag_pd}, {2'b01, 2'b10, 2'b00});
    ov_flag = 1'b1;
    step(3);
    check("R8 overvoltage", {hs, ls, diag_pd}, 6'b0);
    ov_flag = 1'b0;
    step(10);
    check("R8 recovery ov", {hs, ls, diag_pd}, {2'b01, 2'b10, 2'b00});

    // R10 test mode
    test_req = 1'b1; noload = 2'b10;
    step(10);
    check("R10 test mode", {hs, ls, diag_pd}, {2'b01, 2'b00, 2'b10});
    test_req = 1'b0; noload = 2'b00;
    step(10);
    check("R10 exit test", {hs, ls, diag_pd}, {2'b01, 2'b10, 2'b00});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule